// File: doc/BRIEF.md
# Indirect Interrupt Router Register Window

This block is the software-facing register front end of an interrupt routing controller with a parameterised number of input pins (24 by default). Software sees two 32-bit registers at fixed byte offsets: a select register and a data window. The value held in the select register chooses what the window reaches. The choices are an identification register, a read-only version register, a mirror of the identification register that ignores writes, or one 32-bit half of a pin's 64-bit redirection entry.

The block owns the redirection table and presents every entry's decoded fields on flat output vectors for the servicing logic. The servicing logic can set an entry's remote-IRR status bit through a strobe. When software reprograms an entry whose pin already has a pending request, the block raises a one-cycle service request that names that pin.

A small state machine sequences the accesses. `ST_IDLE` accepts one request. An accepted read moves to `ST_READ_RSP`, which presents the read data for one cycle. An accepted table write to a pin with its pending bit set moves to `ST_SVC_REQ`, which pulses the service request for one cycle. Every other accepted request stays in `ST_IDLE`. Both `ST_READ_RSP` and `ST_SVC_REQ` always return to `ST_IDLE` on the next cycle.

Top module: `irq_route_window`

## Requirements
- R1: After reset the select register reads 0 and the identifier reads 0. Every entry has its mask bit (bit 16) set and all its other bits 0. `req_ready` is 1, and `rd_valid` and `svc_valid` are 0.
- R2: Byte offset 0x00 is the select register, which reads back the last 32-bit value written to it. Byte offset 0x10 is the data window. A read at any other offset returns 0, and a write at any other offset changes nothing.
- R3: A select value of 0x10 or more reaches entry (select − 0x10) >> 1. Select bit 0 = 1 reaches bits 63:32 of the entry, and select bit 0 = 0 reaches bits 31:0.
- R4: With select = 0x01, the window reads (pin count − 1) in bits 23:16 and the version code in bits 7:0, with all other bits 0. Writes there change nothing.
- R5: With select = 0x00, a window write loads a 4-bit identifier from data bits 27:24, and the window reads it back in bits 27:24 with all other bits 0. With select = 0x02 the window reads the same value, and writes there are ignored.
- R6: A write to the lower half of an entry clears its remote-IRR bit (bit 14), whatever data bit 14 holds. A write to the upper half keeps it. A `rirr_set_valid` strobe sets it for `rirr_set_pin`.
- R7: A select value whose entry index is at or beyond the pin count, or any value from 0x03 to 0x0F, reads 0 through the window. A write there changes no entry.
- R8: `req_size` encodes the access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Writes of width 1 or 2 bytes are dropped entirely.
- R9: An accepted entry write (either half) while `pin_pending` is set for that pin makes `svc_valid` high for exactly the next cycle, with `svc_pin` equal to the entry index. No other access raises it.
- R10: Field outputs per pin p: vector = bits 7:0, delivery mode = bits 10:8, destination mode = bit 11, polarity = bit 13, remote IRR = bit 14, trigger mode = bit 15, mask = bit 16, destination ID = bits 63:56.
- R11: An accepted read gives `rd_valid` high with the data for exactly the next cycle. `req_ready` is low while a read response or a service request is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | High in the idle state; a request is taken when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the access |
| req_size | input | 2 | Access width code (R8) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pin_pending | input | PINS | Request bit per pin from the sampling logic |
| rirr_set_valid | input | 1 | Set remote IRR strobe |
| rirr_set_pin | input | IDX_W | Pin whose remote IRR is set |
| svc_valid | output | 1 | Service request pulse |
| svc_pin | output | IDX_W | Pin to service |
| fld_vector | output | PINS*8 | Vector field of each entry |
| fld_dlv_mode | output | PINS*3 | Delivery mode of each entry |
| fld_dst_mode | output | PINS | Destination mode of each entry |
| fld_polarity | output | PINS | Polarity of each entry |
| fld_remote_irr | output | PINS | Remote IRR of each entry |
| fld_trigger | output | PINS | Trigger mode of each entry |
| fld_mask | output | PINS | Mask of each entry |
| fld_dest_id | output | PINS*8 | Destination ID of each entry |

## Verification
The assertions assume that `req_valid` and its fields are held stable while presented. They also assume that a set strobe for remote IRR never lands in the same cycle as an accepted write, because the checker's set property excludes that overlap. The stimulus applies every access from a task that waits for `req_ready` and holds the request for exactly one accepting edge. It pulses the set strobe only between accesses. It changes `pin_pending` only when no access is in flight.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_RSP,
        ST_SVC_REQ
    } route_state_e;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_ID,
        WK_VER,
        WK_ARB,
        WK_ENTRY
    } win_kind_e;

    localparam logic [7:0]  OFS_SELECT   = 8'h00;
    localparam logic [7:0]  OFS_WINDOW   = 8'h10;
    localparam logic [31:0] SEL_ID       = 32'h0;
    localparam logic [31:0] SEL_VER      = 32'h1;
    localparam logic [31:0] SEL_ARB      = 32'h2;
    localparam logic [31:0] SEL_TBL_BASE = 32'h10;

    localparam logic [1:0]  SZ_WORD      = 2'd2;
    localparam logic [1:0]  SZ_DWORD     = 2'd3;

    localparam int          B_DST_MODE   = 11;
    localparam int          B_POLARITY   = 13;
    localparam int          B_RIRR       = 14;
    localparam int          B_TRIGGER    = 15;
    localparam int          B_MASK       = 16;
    localparam logic [63:0] ENTRY_RESET  = 64'h1 << B_MASK;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int IDX_W = 5
) (
    input  logic [7:0]       addr,
    input  logic [31:0]      sel,
    output logic             hit_sel,
    output logic             hit_win,
    output win_kind_e        kind,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);

    logic [31:0] offset;
    logic [31:0] slot;

    always_comb begin
        hit_sel = (addr == OFS_SELECT);
        hit_win = (addr == OFS_WINDOW);
        offset  = sel - SEL_TBL_BASE;
        slot    = offset >> 1;
        hi      = sel[0];
        idx     = slot[IDX_W-1:0];
        if (sel == SEL_ID)
            kind = WK_ID;
        else if (sel == SEL_VER)
            kind = WK_VER;
        else if (sel == SEL_ARB)
            kind = WK_ARB;
        else if ((sel >= SEL_TBL_BASE) && (slot < 32'(PINS)))
            kind = WK_ENTRY;
        else
            kind = WK_NONE;
    end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int IDX_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_hi,
    input  logic [31:0]        wr_data,
    input  logic               set_vld,
    input  logic [IDX_W-1:0]   set_pin,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic               rd_hi,
    output logic [31:0]        rd_word,
    output logic [PINS*64-1:0] tbl_flat
);

    for (genvar g = 0; g < PINS; g++) begin : g_entry
        logic [63:0] ent_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= ENTRY_RESET;
            end else begin
                if (set_vld && (set_pin == IDX_W'(g)))
                    ent_q[B_RIRR] <= 1'b1;
                if (wr_en && (wr_idx == IDX_W'(g))) begin
                    if (wr_hi) begin
                        ent_q[63:32] <= wr_data;
                    end else begin
                        ent_q[31:0]   <= wr_data;
                        ent_q[B_RIRR] <= 1'b0;
                    end
                end
            end
        end

        assign tbl_flat[g*64 +: 64] = ent_q;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < PINS; i++) begin
            if (rd_idx == IDX_W'(i))
                rd_word = rd_hi ? tbl_flat[i*64+32 +: 32] : tbl_flat[i*64 +: 32];
        end
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_read,
    input  logic             acc_svc,
    input  logic [IDX_W-1:0] acc_pin,
    output logic             req_ready,
    output logic             rd_valid,
    output logic             svc_valid,
    output logic [IDX_W-1:0] svc_pin
);

    route_state_e     state_q, state_d;
    logic [IDX_W-1:0] pin_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_read)
                    state_d = ST_READ_RSP;
                else if (acc_svc)
                    state_d = ST_SVC_REQ;
            end
            ST_READ_RSP: state_d = ST_IDLE;
            ST_SVC_REQ:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pin_q   <= '0;
        end else begin
            state_q <= state_d;
            if (acc_svc)
                pin_q <= acc_pin;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        rd_valid  = 1'b0;
        svc_valid = 1'b0;
        svc_pin   = pin_q;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_READ_RSP: rd_valid  = 1'b1;
            ST_SVC_REQ:  svc_valid = 1'b1;
            default:     req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_route_window.sv
module irq_route_window
    import irq_route_pkg::*;
#(
    parameter int         PINS    = 24,
    parameter logic [7:0] VERSION = 8'h11,
    localparam int        IDX_W   = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic [PINS-1:0]   pin_pending,
    input  logic              rirr_set_valid,
    input  logic [IDX_W-1:0]  rirr_set_pin,
    output logic              svc_valid,
    output logic [IDX_W-1:0]  svc_pin,
    output logic [PINS*8-1:0] fld_vector,
    output logic [PINS*3-1:0] fld_dlv_mode,
    output logic [PINS-1:0]   fld_dst_mode,
    output logic [PINS-1:0]   fld_polarity,
    output logic [PINS-1:0]   fld_remote_irr,
    output logic [PINS-1:0]   fld_trigger,
    output logic [PINS-1:0]   fld_mask,
    output logic [PINS*8-1:0] fld_dest_id
);

    logic [31:0]        sel_q;
    logic [3:0]         id_q;
    logic [31:0]        rdata_q, rdata_d;
    logic               hit_sel, hit_win, ent_hi;
    win_kind_e          kind;
    logic [IDX_W-1:0]   ent_idx;
    logic [31:0]        tbl_word;
    logic [PINS*64-1:0] tbl_flat;
    logic               accept, size_ok, wr_ok, tbl_wr, acc_read, acc_svc;

    irq_route_decode #(.PINS(PINS), .IDX_W(IDX_W)) u_decode (
        .addr    (req_addr),
        .sel     (sel_q),
        .hit_sel (hit_sel),
        .hit_win (hit_win),
        .kind    (kind),
        .idx     (ent_idx),
        .hi      (ent_hi)
    );

    always_comb begin
        accept   = req_valid && req_ready;
        size_ok  = (req_size == SZ_WORD) || (req_size == SZ_DWORD);
        wr_ok    = accept && req_write && size_ok;
        tbl_wr   = wr_ok && hit_win && (kind == WK_ENTRY);
        acc_read = accept && !req_write;
        acc_svc  = tbl_wr && pin_pending[ent_idx];
    end

    irq_route_table #(.PINS(PINS), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_idx   (ent_idx),
        .wr_hi    (ent_hi),
        .wr_data  (req_wdata),
        .set_vld  (rirr_set_valid),
        .set_pin  (rirr_set_pin),
        .rd_idx   (ent_idx),
        .rd_hi    (ent_hi),
        .rd_word  (tbl_word),
        .tbl_flat (tbl_flat)
    );

    irq_route_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_read  (acc_read),
        .acc_svc   (acc_svc),
        .acc_pin   (ent_idx),
        .req_ready (req_ready),
        .rd_valid  (rd_valid),
        .svc_valid (svc_valid),
        .svc_pin   (svc_pin)
    );

    always_comb begin
        rdata_d = '0;
        if (hit_sel) begin
            rdata_d = sel_q;
        end else if (hit_win) begin
            unique case (kind)
                WK_ID, WK_ARB: rdata_d = {4'h0, id_q, 24'h0};
                WK_VER:        rdata_d = {8'h0, 8'(PINS - 1), 8'h0, VERSION};
                WK_ENTRY:      rdata_d = tbl_word;
                default:       rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            id_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_ok && hit_sel)
                sel_q <= req_wdata;
            if (wr_ok && hit_win && (kind == WK_ID))
                id_q <= req_wdata[27:24];
            if (acc_read)
                rdata_q <= rdata_d;
        end
    end

    assign rd_data = rdata_q;

    for (genvar p = 0; p < PINS; p++) begin : g_fields
        assign fld_vector[p*8 +: 8]   = tbl_flat[p*64 +: 8];
        assign fld_dlv_mode[p*3 +: 3] = tbl_flat[p*64 + 8 +: 3];
        assign fld_dst_mode[p]        = tbl_flat[p*64 + B_DST_MODE];
        assign fld_polarity[p]        = tbl_flat[p*64 + B_POLARITY];
        assign fld_remote_irr[p]      = tbl_flat[p*64 + B_RIRR];
        assign fld_trigger[p]         = tbl_flat[p*64 + B_TRIGGER];
        assign fld_mask[p]            = tbl_flat[p*64 + B_MASK];
        assign fld_dest_id[p*8 +: 8]  = tbl_flat[p*64 + 56 +: 8];
    end

endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker #(
    parameter int PINS  = 24,
    parameter int IDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic              rd_valid,
    input logic              rirr_set_valid,
    input logic [IDX_W-1:0]  rirr_set_pin,
    input logic              svc_valid,
    input logic [PINS*8-1:0] fld_vector,
    input logic [PINS-1:0]   fld_mask,
    input logic [PINS-1:0]   fld_remote_irr
);

    logic acc_rd, acc_wr, small_wr;
    assign acc_rd   = req_valid && req_ready && !req_write;
    assign acc_wr   = req_valid && req_ready && req_write;
    assign small_wr = acc_wr && (req_size < 2'd2);

    assert_read_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rd_valid);

    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || svc_valid) |-> !req_ready);

    assert_rsp_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && svc_valid));

    assert_svc_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |=> !svc_valid);

    assert_svc_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> $past(acc_wr));

    assert_small_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        small_wr |=> (!svc_valid && $stable(fld_vector) && $stable(fld_mask)));

    assert_rirr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_set_valid && (32'(rirr_set_pin) < PINS) && !acc_wr)
        |=> fld_remote_irr[$past(rirr_set_pin)]);

endmodule

bind irq_route_window irq_route_checker #(.PINS(PINS), .IDX_W(IDX_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_size       (req_size),
    .rd_valid       (rd_valid),
    .rirr_set_valid (rirr_set_valid),
    .rirr_set_pin   (rirr_set_pin),
    .svc_valid      (svc_valid),
    .fld_vector     (fld_vector),
    .fld_mask       (fld_mask),
    .fld_remote_irr (fld_remote_irr)
);

// File: tb/irq_route_window_tb_top.sv
module irq_route_window_tb_top;

    localparam int PINS = 24;
    localparam int IW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]      req_addr = '0;
    logic [1:0]      req_size = '0;
    logic [31:0]     req_wdata = '0;
    logic            req_ready, rd_valid, svc_valid;
    logic [31:0]     rd_data;
    logic [PINS-1:0] pend = '0;
    logic            rset_v = 1'b0;
    logic [IW-1:0]   rset_p = '0;
    logic [IW-1:0]   svc_pin;
    logic [PINS*8-1:0] f_vec, f_dst;
    logic [PINS*3-1:0] f_dlv;
    logic [PINS-1:0] f_dm, f_pol, f_rirr, f_trg, f_msk;

    always #5 clk = ~clk;

    irq_route_window dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .pin_pending(pend), .rirr_set_valid(rset_v), .rirr_set_pin(rset_p),
        .svc_valid(svc_valid), .svc_pin(svc_pin), .fld_vector(f_vec),
        .fld_dlv_mode(f_dlv), .fld_dst_mode(f_dm), .fld_polarity(f_pol),
        .fld_remote_irr(f_rirr), .fld_trigger(f_trg), .fld_mask(f_msk),
        .fld_dest_id(f_dst)
    );

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_rd[$];
    string       rd_tag[$];
    int          exp_svc[$];

    logic [63:0] m_tbl [PINS];
    logic [31:0] m_sel;
    logic [3:0]  m_id;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit ent_ok(input logic [31:0] s);
        return (s >= 32'h10) && (((s - 32'h10) >> 1) < PINS);
    endfunction

    // driver: updates the model, pushes expectations, applies the access
    task automatic bus_op(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input string tag);
        int i;
        logic [31:0] e;
        if (!wr) begin
            e = 32'h0;
            if (a == 8'h00) e = m_sel;
            else if (a == 8'h10) begin
                if (m_sel == 0 || m_sel == 2) e = {4'h0, m_id, 24'h0};
                else if (m_sel == 1) e = {8'h0, 8'(PINS - 1), 8'h0, 8'h11};
                else if (ent_ok(m_sel)) begin
                    i = int'((m_sel - 32'h10) >> 1);
                    e = m_sel[0] ? m_tbl[i][63:32] : m_tbl[i][31:0];
                end
            end
            exp_rd.push_back(e);
            rd_tag.push_back(tag);
        end else if (sz >= 2'd2) begin
            if (a == 8'h00) m_sel = d;
            else if (a == 8'h10) begin
                if (m_sel == 0) m_id = d[27:24];
                else if (ent_ok(m_sel)) begin
                    i = int'((m_sel - 32'h10) >> 1);
                    if (m_sel[0]) m_tbl[i][63:32] = d;
                    else begin
                        m_tbl[i][31:0] = d;
                        m_tbl[i][14] = 1'b0;
                    end
                    if (pend[i]) exp_svc.push_back(i);
                end
            end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d, input string tag);
        bus_op(1'b1, a, 2'd2, d, tag);
    endtask

    task automatic rd32(input logic [7:0] a, input string tag);
        bus_op(1'b0, a, 2'd2, 32'h0, tag);
    endtask

    task automatic set_rirr(input int p);
        @(negedge clk);
        rset_v = 1'b1; rset_p = IW'(p);
        m_tbl[p][14] = 1'b1;
        @(negedge clk);
        rset_v = 1'b0;
    endtask

    // monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            check(!req_ready, "R11 ready low in response", 64'(req_ready), 64'h0);
            if (exp_rd.size() == 0)
                check(1'b0, "R11 unexpected read response", 64'(rd_data), 64'h0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_rd.pop_front();
                t = rd_tag.pop_front();
                check(rd_data == e, t, 64'(rd_data), 64'(e));
            end
        end
        if (rst_n && svc_valid) begin
            if (exp_svc.size() == 0)
                check(1'b0, "R9 unexpected service request", 64'(svc_pin), 64'h0);
            else begin
                int ep;
                ep = exp_svc.pop_front();
                check(svc_pin == IW'(ep), "R9 service pin", 64'(svc_pin), 64'(ep));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < PINS; i++) m_tbl[i] = 64'h1 << 16;
        m_sel = '0;
        m_id  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(&f_msk, "R1 masks set", 64'(f_msk), 64'hFFFFFF);
        check(req_ready && !rd_valid && !svc_valid, "R1 handshake idle",
              {61'h0, req_ready, rd_valid, svc_valid}, 64'h4);
        rd32(8'h00, "R1 select reset");
        rd32(8'h10, "R1 id reset");
        wr32(8'h00, 32'h1A, "R2");
        rd32(8'h10, "R1 entry reset value");
        // R2 select and offsets
        wr32(8'h00, 32'h25, "R2");
        rd32(8'h00, "R2 select readback");
        rd32(8'h08, "R2 undecoded read");
        wr32(8'h20, 32'hDEAD, "R2");
        rd32(8'h00, "R2 undecoded write ignored");
        // R4 version
        wr32(8'h00, 32'h1, "R4");
        rd32(8'h10, "R4 version");
        wr32(8'h10, 32'hFFFFFFFF, "R4");
        rd32(8'h10, "R4 version write ignored");
        // R5 identifier
        wr32(8'h00, 32'h0, "R5");
        wr32(8'h10, 32'hA5000000, "R5");
        rd32(8'h10, "R5 id readback");
        wr32(8'h00, 32'h2, "R5");
        rd32(8'h10, "R5 arbitration mirror");
        wr32(8'h10, 32'h0F000000, "R5");
        wr32(8'h00, 32'h0, "R5");
        rd32(8'h10, "R5 arbitration write ignored");
        // R3 / R10 entry halves and fields, pin 3
        wr32(8'h00, 32'h16, "R3");
        wr32(8'h10, 32'h0000AB42, "R3");
        wr32(8'h00, 32'h17, "R3");
        bus_op(1'b1, 8'h10, 2'd3, 32'hC7000000, "R8 eight byte write");
        check(f_vec[3*8 +: 8] == 8'h42, "R10 vector", 64'(f_vec[3*8 +: 8]), 64'h42);
        check(f_dlv[3*3 +: 3] == 3'd3, "R10 delivery mode", 64'(f_dlv[3*3 +: 3]), 64'd3);
        check(f_dm[3] && f_pol[3] && f_trg[3] && !f_msk[3], "R10 single bits",
              {60'h0, f_dm[3], f_pol[3], f_trg[3], f_msk[3]}, 64'hE);
        check(f_dst[3*8 +: 8] == 8'hC7, "R10 destination", 64'(f_dst[3*8 +: 8]), 64'hC7);
        rd32(8'h10, "R3 upper half readback");
        wr32(8'h00, 32'h16, "R3");
        rd32(8'h10, "R3 lower half readback");
        // R3 last pin
        wr32(8'h00, 32'h3F, "R3");
        wr32(8'h10, 32'h5A000000, "R3");
        rd32(8'h10, "R3 last pin upper");
        check(f_dst[23*8 +: 8] == 8'h5A, "R3 last pin field", 64'(f_dst[23*8 +: 8]), 64'h5A);
        // R7 out of range
        wr32(8'h00, 32'h40, "R7");
        wr32(8'h10, 32'h12345678, "R7");
        rd32(8'h10, "R7 beyond table reads 0");
        wr32(8'h00, 32'h05, "R7");
        wr32(8'h10, 32'h87654321, "R7");
        rd32(8'h10, "R7 gap select reads 0");
        wr32(8'h00, 32'h10, "R7");
        rd32(8'h10, "R7 pin 0 untouched");
        // R8 narrow writes
        bus_op(1'b1, 8'h00, 2'd1, 32'h99, "R8 narrow select write");
        rd32(8'h00, "R8 select unchanged");
        bus_op(1'b1, 8'h10, 2'd0, 32'h000000FF, "R8 narrow window write");
        rd32(8'h10, "R8 entry unchanged");
        // R6 remote IRR
        set_rirr(3);
        check(f_rirr[3], "R6 set strobe", 64'(f_rirr[3]), 64'h1);
        wr32(8'h00, 32'h17, "R6");
        wr32(8'h10, 32'h11000000, "R6");
        check(f_rirr[3], "R6 upper write keeps", 64'(f_rirr[3]), 64'h1);
        wr32(8'h00, 32'h16, "R6");
        rd32(8'h10, "R6 status visible in low half");
        wr32(8'h10, 32'h00004042, "R6");
        check(!f_rirr[3], "R6 low write clears", 64'(f_rirr[3]), 64'h0);
        rd32(8'h10, "R6 cleared in readback");
        // R9 service requests
        pend = 24'h000080;
        wr32(8'h00, 32'h1E, "R9");
        wr32(8'h10, 32'h00000031, "R9 low write on pending pin");
        wr32(8'h00, 32'h1F, "R9");
        wr32(8'h10, 32'h01000000, "R9 high write on pending pin");
        bus_op(1'b1, 8'h10, 2'd1, 32'h02000000, "R9 narrow write no service");
        wr32(8'h00, 32'h1C, "R9");
        wr32(8'h10, 32'h00000077, "R9 other pin no service");
        pend = '0;
        repeat (4) @(negedge clk);
        check(exp_rd.size() == 0 && exp_svc.size() == 0, "R9 R11 all results seen",
              64'(exp_rd.size() + exp_svc.size()), 64'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule